// File: doc/BRIEF.md
# Two-Stage Selectable Speed-Reference Divider

This block derives the speed-reference tick for a motor phase-locked speed loop from a crystal-derived clock. The clock is divided by the product of two factors. A prescaler factor of 5, 4 or 3 is chosen by one three-level select. A power-of-two factor is chosen by a pair of three-level selects. Together the three selects give 24 divide modes.

The selects arrive already decoded, each as a 2-bit level code. When both selects of the pair are at the low level, the divider is bypassed. An external reference input is then synchronized to the clock and passed through.

Two outputs are provided. One is a single-cycle pulse, once per reference period. The other is a 50% square wave at the same rate. Any change of the selects restarts both counter stages, so the new period is never truncated or stretched by the old count.

Top module: `ref_divider`

## Requirements
- R1: The prescaler factor P follows `pre_sel`: code 2'b00 (low) gives 5, 2'b01 (middle) gives 4, and 2'b10 (high) gives 3.
- R2: The second-stage factor is M = 2^(BASE_LOG2 + k - 1), where k = 3*level(`hi_sel`) + level(`lo_sel`) and the levels are low=0, middle=1, high=2. With the default BASE_LOG2=7, M runs from 128 (k=1) to 16384 (k=8).
- R3: In divide mode, `ref_tick` is high for exactly one cycle in every P*M cycles.
- R4: Both outputs are low or idle during reset (`ref_tick`=0). After reset is released, the first `ref_tick` is high in the P*M-th cycle.
- R5: A change on any select restarts both stages. In divide mode, the first `ref_tick` after the change is high in cycle P*M+1, counted from the change.
- R6: When k=0 (both of the pair low), the block is in external mode. `ref_tick` pulses for one cycle, 3 cycles after each rising edge of `ext_ref`. A held-high level gives no further pulses.
- R7: In external mode, `ref_sq` follows `ext_ref`, delayed by 3 cycles.
- R8: In divide mode, `ref_sq` is high for the first P*M/2 cycles of each period. The period starts at the cycle in which `ref_tick` is high.
- R9: The reserved code 2'b11 on any select is treated as the high level.
- R10: `ref_tick` is never high in two consecutive cycles.
- R11: In divide mode, `ext_ref` has no effect on `ref_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescaler level code (00 low, 01 middle, 10/11 high) |
| hi_sel | input | 2 | Upper level code of the power-of-two select pair |
| lo_sel | input | 2 | Lower level code of the power-of-two select pair |
| ext_ref | input | 1 | External reference, asynchronous, used when the pair is low/low |
| ref_tick | output | 1 | One-cycle reference pulse |
| ref_sq | output | 1 | 50% reference square wave |

## Verification
Each result falls due at a cycle counted from its stimulus, and every check samples at that cycle:
- After reset is released, the first pulse falls due at sample P*M.
- After a select change, the first pulse falls due at sample P*M+1. The extra cycle is the restart edge.
- Later pulses follow every P*M samples.
- In external mode, the pulse and the square-wave level both appear at the third sample after the input edge, because of the two synchronizer flops and the edge register.

Every sample is taken on the falling clock edge, and stimulus is applied just after that edge. Each expected count is therefore an exact sample index and never a range.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Level numbers: low=0, middle=1, high=2 (reserved 2'b11 counts as high)
  function automatic logic [1:0] level_of(input logic [1:0] code);
    if (code == 2'b00)      return 2'd0;
    else if (code == 2'b01) return 2'd1;
    else                    return 2'd2;
  endfunction

  // Prescaler factor from its level
  function automatic logic [2:0] first_div(input logic [1:0] code);
    case (level_of(code))
      2'd0:    return 3'd5;
      2'd1:    return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

  // Index of the power-of-two stage; 0 selects external mode
  function automatic logic [3:0] second_idx(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] h;
    logic [3:0] l;
    h = {2'b00, level_of(hi)};
    l = {2'b00, level_of(lo)};
    return h * 4'd3 + l;
  endfunction

endpackage

// File: rtl/refdiv_select.sv
module refdiv_select
  import refdiv_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int LW        = 4
) (
  input  logic          clk,
  input  logic [1:0]    pre_sel,
  input  logic [1:0]    hi_sel,
  input  logic [1:0]    lo_sel,
  output logic [2:0]    pre_div,
  output logic [LW-1:0] s2_log,
  output logic          ext_mode,
  output logic          restart
);

  logic [5:0] sel_now;
  logic [5:0] sel_q;
  logic [3:0] idx;

  assign sel_now  = {pre_sel, hi_sel, lo_sel};
  assign idx      = second_idx(hi_sel, lo_sel);
  assign pre_div  = first_div(pre_sel);
  assign ext_mode = (idx == 4'd0);
  assign s2_log   = ext_mode ? LW'(BASE_LOG2) : LW'(BASE_LOG2 + int'(idx) - 1);

  // Captured without reset so that it already matches the selects when reset ends
  always_ff @(posedge clk) sel_q <= sel_now;

  assign restart = (sel_now != sel_q);

endmodule

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] div,
  output logic [2:0] cnt,
  output logic       wrap
);

  assign wrap = run && !restart && (cnt == div - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (wrap)              cnt <= '0;
    else                        cnt <= cnt + 3'd1;
  end

endmodule

// File: rtl/refdiv_stage2.sv
module refdiv_stage2 #(
  parameter int S2W = 14,
  parameter int LW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           run,
  input  logic           step,
  input  logic [LW-1:0]  log2m,
  output logic [S2W-1:0] cnt,
  output logic           wrap,
  output logic           low_half
);

  localparam logic [LW-1:0]  S2W_L = LW'(S2W);
  localparam logic [S2W-1:0] ONES  = {S2W{1'b1}};

  logic [S2W-1:0] lim;

  assign lim      = ONES >> (S2W_L - log2m);
  assign wrap     = run && !restart && step && (cnt == lim);
  assign low_half = (cnt <= (lim >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (wrap)            cnt <= '0;
    else if (step)            cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/refdiv_extsync.sv
module refdiv_extsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref,
  output logic rise,
  output logic level
);

  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], ext_ref};
  end

  assign rise  = sh[1] && !sh[2];
  assign level = sh[2];

endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import refdiv_pkg::*;
#(
  parameter int BASE_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pre_sel,
  input  logic [1:0] hi_sel,
  input  logic [1:0] lo_sel,
  input  logic       ext_ref,
  output logic       ref_tick,
  output logic       ref_sq
);

  localparam int S2W = BASE_LOG2 + 7;
  localparam int LW  = $clog2(S2W + 1);

  logic [2:0]     pre_div;
  logic [LW-1:0]  s2_log;
  logic           ext_mode;
  logic           restart;
  logic [2:0]     pre_cnt;
  logic           pre_wrap;
  logic [S2W-1:0] s2_cnt;
  logic           s2_wrap;
  logic           low_half;
  logic           ext_rise;
  logic           ext_level;
  logic           tick_q;

  refdiv_select #(.BASE_LOG2(BASE_LOG2), .LW(LW)) u_sel (
    .clk(clk), .pre_sel(pre_sel), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .pre_div(pre_div), .s2_log(s2_log), .ext_mode(ext_mode), .restart(restart)
  );

  refdiv_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(!ext_mode),
    .div(pre_div), .cnt(pre_cnt), .wrap(pre_wrap)
  );

  refdiv_stage2 #(.S2W(S2W), .LW(LW)) u_s2 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(!ext_mode),
    .step(pre_wrap), .log2m(s2_log), .cnt(s2_cnt), .wrap(s2_wrap),
    .low_half(low_half)
  );

  refdiv_extsync u_ext (
    .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .rise(ext_rise), .level(ext_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tick_q <= 1'b0;
    else if (ext_mode) tick_q <= ext_rise;
    else               tick_q <= s2_wrap;
  end

  assign ref_tick = tick_q;
  assign ref_sq   = ext_mode ? ext_level : low_half;

endmodule

// File: rtl/ref_divider_chk.sv
module ref_divider_chk #(
  parameter int S2W = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ext_mode,
  input logic           restart,
  input logic           pre_wrap,
  input logic           s2_wrap,
  input logic [2:0]     pre_cnt,
  input logic [2:0]     pre_div,
  input logic [S2W-1:0] s2_cnt,
  input logic           ref_tick
);

  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);

  p_restart_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_cnt == 3'd0 && s2_cnt == '0));

  p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (pre_cnt < pre_div));

  p_wrap_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_wrap && !ext_mode) |=> ref_tick);

  p_s2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wrap && !restart) |=> $stable(s2_cnt));

  p_ext_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> (pre_cnt == 3'd0 && s2_cnt == '0));

  p_tick_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> ($past(ext_mode) || $past(s2_wrap)));

endmodule

bind ref_divider ref_divider_chk #(.S2W(S2W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .restart(restart),
  .pre_wrap(pre_wrap), .s2_wrap(s2_wrap), .pre_cnt(pre_cnt),
  .pre_div(pre_div), .s2_cnt(s2_cnt), .ref_tick(ref_tick)
);

// File: tb/test_ref_divider.sv
`timescale 1ns/1ps
module test_ref_divider;

  localparam int BL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pre_sel = 2'b01;
  logic [1:0] hi_sel  = 2'b00;
  logic [1:0] lo_sel  = 2'b01;
  logic ext_ref = 1'b0;
  logic ref_tick;
  logic ref_sq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ref_divider #(.BASE_LOG2(BL)) i_ref_divider (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .hi_sel(hi_sel),
    .lo_sel(lo_sel), .ext_ref(ext_ref), .ref_tick(ref_tick), .ref_sq(ref_sq)
  );

  // Expected factors, written independently of the design
  function automatic int exp_p(input logic [1:0] c);
    if (c == 2'b00) return 5;
    if (c == 2'b01) return 4;
    return 3;
  endfunction

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b11) ? 2 : int'(c);
  endfunction

  function automatic int exp_m(input logic [1:0] h, input logic [1:0] l);
    int k;
    int m;
    k = lvl(h) * 3 + lvl(l);
    m = 1;
    for (int i = 0; i < BL + k - 1; i++) m = m * 2;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count falling-edge samples up to and including the next tick
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_tick && n < 20000);
  endtask

  task automatic set_sel(input logic [1:0] p, input logic [1:0] h, input logic [1:0] l);
    pre_sel = p;
    hi_sel  = h;
    lo_sel  = l;
  endtask

  task automatic t_reset_latency;
    int n;
    int tot;
    rst_n = 1'b0;
    set_sel(2'b00, 2'b00, 2'b10);
    repeat (3) @(negedge clk);
    check(ref_tick == 1'b0, "R4 reset tick", int'(ref_tick), 0);
    tot = exp_p(2'b00) * exp_m(2'b00, 2'b10);
    rst_n = 1'b1;
    wait_tick(n);
    check(n == tot, "R4 first tick after reset", n, tot);
  endtask

  task automatic t_prescaler;
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    int n;
    int tot;
    foreach (codes[i]) begin
      set_sel(codes[i], 2'b00, 2'b01);
      tot = exp_p(codes[i]) * exp_m(2'b00, 2'b01);
      wait_tick(n);
      check(n == tot + 1, "R5 first tick after select change", n, tot + 1);
      wait_tick(n);
      check(n == tot, (codes[i] == 2'b11) ? "R9 reserved prescaler code" : "R1 prescaler period", n, tot);
    end
  endtask

  task automatic t_stage2;
    int n;
    int tot;
    for (int k = 1; k < 9; k++) begin
      logic [1:0] h;
      logic [1:0] l;
      h = 2'(k / 3);
      l = 2'(k % 3);
      set_sel(2'b01, h, l);
      tot = exp_p(2'b01) * exp_m(h, l);
      wait_tick(n);
      check(n == tot + 1, "R5 restart on pair change", n, tot + 1);
      wait_tick(n);
      check(n == tot, "R2 second stage period", n, tot);
    end
    set_sel(2'b10, 2'b11, 2'b11);
    tot = 3 * exp_m(2'b10, 2'b10);
    wait_tick(n);
    wait_tick(n);
    check(n == tot, "R9 reserved pair codes", n, tot);
  endtask

  task automatic t_square_single;
    int n;
    int hi;
    int tot;
    int ticks;
    set_sel(2'b00, 2'b01, 2'b00);
    tot = 5 * exp_m(2'b01, 2'b00);
    wait_tick(n);
    hi = ref_sq ? 1 : 0;
    ticks = 1;
    for (int i = 1; i < tot; i++) begin
      @(negedge clk);
      if (ref_sq) hi++;
      if (ref_tick) ticks++;
      if (i == 1) check(ref_tick == 1'b0, "R10 tick one cycle", int'(ref_tick), 0);
    end
    check(hi == tot / 2, "R8 square high cycles", hi, tot / 2);
    check(ticks == 1, "R3 one tick per period", ticks, 1);
    @(negedge clk);
    check(ref_tick == 1'b1, "R3 tick at period end", int'(ref_tick), 1);
  endtask

  task automatic t_ignore_ext;
    int n;
    int tot;
    set_sel(2'b10, 2'b00, 2'b10);
    tot = 3 * exp_m(2'b00, 2'b10);
    wait_tick(n);
    for (int i = 0; i < tot - 1; i++) begin
      @(negedge clk);
      ext_ref = ~ext_ref;
      if (ref_tick) n = -1;
    end
    check(n != -1, "R11 ext input ignored in divide mode", n, tot + 1);
    @(negedge clk);
    check(ref_tick == 1'b1, "R11 period kept with ext toggling", int'(ref_tick), 1);
    ext_ref = 1'b0;
  endtask

  task automatic t_external;
    int ticks;
    set_sel(2'b01, 2'b00, 2'b00);
    repeat (6) @(negedge clk);
    check(ref_tick == 1'b0 && ref_sq == 1'b0, "R6 external idle", int'(ref_tick), 0);
    ext_ref = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ref_tick == 1'b0, "R6 no tick before 3 cycles", int'(ref_tick), 0);
    check(ref_sq == 1'b0, "R7 square delayed", int'(ref_sq), 0);
    @(negedge clk);
    check(ref_tick == 1'b1, "R6 tick 3 cycles after rise", int'(ref_tick), 1);
    check(ref_sq == 1'b1, "R7 square follows ext", int'(ref_sq), 1);
    ticks = 0;
    repeat (40) begin
      @(negedge clk);
      if (ref_tick) ticks++;
    end
    check(ticks == 0, "R6 held level gives no pulse", ticks, 0);
    ext_ref = 1'b0;
    repeat (3) @(negedge clk);
    check(ref_sq == 1'b0, "R7 square falls", int'(ref_sq), 0);
    ext_ref = 1'b1;
    repeat (3) @(negedge clk);
    check(ref_tick == 1'b1, "R6 second rise pulses", int'(ref_tick), 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_latency();
    t_prescaler();
    t_stage2();
    t_square_single();
    t_ignore_ext();
    t_external();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule